// File: doc/BRIEF.md
# Byte-Register I2C Target with Auto-Incrementing Pointer

This block is the serial front end of a small register bank. It watches a two-wire I2C bus that is sampled by a faster system clock. It recognises bus START and STOP conditions and answers one 7-bit target address, which a strap input selects from two values. It then moves bytes between the bus and a byte-addressed register bank through a plain address, write-data, write-strobe and read-data port. The block only ever pulls SDA low, as an open-drain output, and it never holds SCL low.

A write transfer starts with a sub-address byte that loads an internal pointer. Each data byte that follows is written to the register at the pointer, and the pointer then steps to the next register. A write that carries only a sub-address just sets the start point for a later read. A read transfer sends bytes from the pointer onward. After each byte the pointer advances, so a read that has no sub-address in front of it picks up one past the last register read. After reset it starts at register 0x00.

Both bus lines pass through a two-stage synchroniser and then a glitch filter before edges are detected. A pulse shorter than the filter length is therefore never seen as a clock edge or as a bus condition.

Top module: `i2c_reg_target`

## Requirements
- R1: With `addr_strap` high the target answers address 7'b1100111 (0x67), and with it low it answers 7'b1000111 (0x47). It acknowledges a matching address byte by pulling SDA low in the ninth clock.
- R2: When the address byte does not match, no acknowledge is given. All later bytes get no acknowledge and cause no register write, until the next START.
- R3: Bytes are shifted MSB first. In a write, the first byte after the address loads the pointer, and every data byte after it gets an acknowledge. Each data byte produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer, and the pointer then steps by one.
- R4: A write that carries only a sub-address and then STOP makes the next read begin at that sub-address.
- R5: A read that has no sub-address write in front of it begins at 0x00 after reset. Otherwise it begins one past the last register read.
- R6: Read bytes are sent MSB first from the register at the pointer. After each byte the target samples the master's bit: 0 (ACK) sends the next register, and 1 (NACK) releases SDA for the rest of the transfer.
- R7: A repeated START restarts address reception exactly like a START and keeps the pointer. After a STOP the target returns to idle and does not drive SDA.
- R8: The target changes its SDA drive only while the filtered SCL is low, except when a START or STOP resets it. In reset it does not drive SDA.
- R9: A pulse on SCL that lasts fewer system clocks than `GLITCH_CYCLES` is ignored, so it does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Selects which of the two target addresses is answered |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 8 | Register pointer presented to the bank |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
On every cycle, the checker confirms that the write strobe lasts a single cycle and occurs only while SCL is low. It also confirms that the SDA drive never switches while filtered SCL is high, outside START and STOP, and that the target lets go of SDA right after a STOP or START. Only the bench's scenarios can show the rest. These are address matching under both strap values, the silence after a wrong address, the pointer behaviour across sub-address-only writes, continued reads and repeated STARTs, the effect of the master's ACK or NACK, and the rejection of SCL glitches. Each of them is judged against a register bank model and a queue of expected writes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  localparam logic [6:0] TGT_ADDR_STRAP_HI = 7'b1100111;
  localparam logic [6:0] TGT_ADDR_STRAP_LO = 7'b1000111;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  localparam int CW = $clog2(GLITCH_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   filt_q, filt_d;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (synced == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(GLITCH_CYCLES - 1)) begin
      filt_d = synced;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign line_o = filt_q;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        my_addr,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] wdata,
  output logic              we,
  output logic              sda_drive
);

  tgt_state_e        state_q, state_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic              rw_q, rw_d;
  logic              we_q, we_d;
  logic              mack_q, mack_d;
  logic              is_rx;

  assign is_rx = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_WDATA);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    sr_d     = sr_q;
    tx_d     = tx_q;
    ptr_d    = ptr_q;
    wdata_d  = wdata_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    we_d     = 1'b0;

    if (start_ev) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
    end else if (stop_ev) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
    end else if (is_rx) begin
      if (scl_rise && (bitcnt_q < 4'd8)) begin
        sr_d     = {sr_q[BYTE_W-2:0], sda_f};
        bitcnt_d = bitcnt_q + 4'd1;
      end
      if (scl_fall && (bitcnt_q == 4'd8)) begin
        bitcnt_d = '0;
        unique case (state_q)
          ST_ADDR: begin
            if (sr_q[7:1] == my_addr) begin
              rw_d    = sr_q[0];
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IGNORE;
            end
          end
          ST_SUB: begin
            ptr_d   = sr_q;
            state_d = ST_SUB_ACK;
          end
          default: begin
            we_d    = 1'b1;
            wdata_d = sr_q;
            state_d = ST_WDATA_ACK;
          end
        endcase
      end
    end else begin
      unique case (state_q)
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (rw_q) begin
              tx_d    = rdata;
              ptr_d   = ptr_q + 8'd1;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_SUB;
            end
          end
        end
        ST_SUB_ACK: begin
          if (scl_fall) state_d = ST_WDATA;
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            ptr_d   = ptr_q + 8'd1;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              bitcnt_d = '0;
              state_d  = ST_RACK;
            end else begin
              tx_d     = {tx_q[BYTE_W-2:0], 1'b0};
              bitcnt_d = bitcnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_d = ~sda_f;
          if (scl_fall) begin
            if (mack_q) begin
              tx_d    = rdata;
              ptr_d   = ptr_q + 8'd1;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      sr_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      wdata_q  <= '0;
      rw_q     <= 1'b0;
      we_q     <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      sr_q     <= sr_d;
      tx_q     <= tx_d;
      ptr_q    <= ptr_d;
      wdata_q  <= wdata_d;
      rw_q     <= rw_d;
      we_q     <= we_d;
      mack_q   <= mack_d;
    end
  end

  assign ptr       = ptr_q;
  assign wdata     = wdata_q;
  assign we        = we_q;
  assign sda_drive = (state_q == ST_ADDR_ACK) || (state_q == ST_SUB_ACK) ||
                     (state_q == ST_WDATA_ACK) ||
                     ((state_q == ST_RDATA) && !tx_q[BYTE_W-1]);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int         SYNC_STAGES   = 2,
  parameter int         GLITCH_CYCLES = 3,
  parameter logic [6:0] ADDR_HI       = TGT_ADDR_STRAP_HI,
  parameter logic [6:0] ADDR_LO       = TGT_ADDR_STRAP_LO
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_strap,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] filt_lines;
  logic              scl_f, sda_f;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic [6:0]        my_addr;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .GLITCH_CYCLES(GLITCH_CYCLES)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign scl_f   = filt_lines[1];
  assign sda_f   = filt_lines[0];
  assign my_addr = addr_strap ? ADDR_HI : ADDR_LO;

  i2c_bus_events u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2c_tgt_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .my_addr  (my_addr),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rdata    (reg_rdata),
    .ptr      (reg_addr),
    .wdata    (reg_wdata),
    .we       (reg_we),
    .sda_drive(sda_oe)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic reg_we
);

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R3
  we_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_f);

  // R8
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !start_ev && !stop_ev) |-> !scl_f);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R7
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_f   (scl_f),
  .start_ev(start_ev),
  .stop_ev (stop_ev),
  .sda_oe  (sda_oe),
  .reg_we  (reg_we)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;

  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_strap;
  logic       scl_m, sda_m;
  logic       sda_w;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;
  logic [7:0] mem [256];

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];

  always #5 clk = ~clk;

  assign sda_w     = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_reg_target u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_strap(addr_strap),
    .scl_i     (scl_m),
    .sda_i     (sda_w),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'(a) ^ 8'h5C;
  endfunction

  // register bank model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for register writes (R3, R2)
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R3 write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic put_bit(bit b, bit glitch);
    sda_m = b;
    if (glitch) begin
      tick(Q/2); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q/2);
    end else begin
      tick(Q);
    end
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    bit b0;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q/2);
    b0 = sda_w; tick(Q);
    b  = sda_w;
    chk(b0 == b, "R8 SDA stable while SCL high", b, b0);
    tick(Q/2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] v, bit glitch, output bit nack);
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
    get_bit(nack);
  endtask

  task automatic recv_byte(bit nack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(nack, 1'b0);
  endtask

  task automatic read_expect(int n, int first, string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, v);
      chk(v == init_val(first + i), req, v, init_val(first + i));
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit nk;
    logic [7:0] v;
    rst_n = 1'b0; addr_strap = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R8 reset sda_oe", sda_oe, 0);
    chk(reg_we == 1'b0, "R3 reset reg_we", reg_we, 0);
    rst_n = 1'b1;
    tick(10);

    // R5: read from 0x00 after reset, then continue
    i2c_start; send_byte(8'hCF, 0, nk);
    chk(nk == 0, "R1 ack strap high read", nk, 0);
    read_expect(2, 8'h00, "R5 read after reset");
    i2c_stop;
    i2c_start; send_byte(8'hCF, 0, nk);
    read_expect(1, 8'h02, "R5 continue from last+1");
    i2c_stop;

    // R3: multi-byte write
    i2c_start; send_byte(8'hCE, 0, nk);
    chk(nk == 0, "R1 ack strap high write", nk, 0);
    send_byte(8'h10, 0, nk); chk(nk == 0, "R3 sub-address ack", nk, 0);
    exp_q.push_back({8'h10, 8'h11}); send_byte(8'h11, 0, nk); chk(nk == 0, "R3 data ack", nk, 0);
    exp_q.push_back({8'h11, 8'h22}); send_byte(8'h22, 0, nk); chk(nk == 0, "R3 data ack", nk, 0);
    exp_q.push_back({8'h12, 8'h33}); send_byte(8'h33, 0, nk); chk(nk == 0, "R3 data ack", nk, 0);
    i2c_stop;
    chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

    // R4, R6: sub-only write then read with ACK,ACK,NACK
    i2c_start; send_byte(8'hCE, 0, nk); send_byte(8'h40, 0, nk); i2c_stop;
    i2c_start; send_byte(8'hCF, 0, nk);
    read_expect(3, 8'h40, "R4 read from sub-address");
    tick(Q);
    chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
    i2c_stop;
    i2c_start; send_byte(8'hCF, 0, nk);
    read_expect(1, 8'h43, "R5 continue after NACK");
    i2c_stop;

    // R2: wrong address, later bytes ignored
    i2c_start; send_byte(8'h8E, 0, nk);
    chk(nk == 1, "R2 no ack wrong address", nk, 1);
    send_byte(8'h10, 0, nk); chk(nk == 1, "R2 no ack after mismatch", nk, 1);
    send_byte(8'h99, 0, nk); chk(nk == 1, "R2 no ack after mismatch", nk, 1);
    i2c_stop;
    i2c_start; send_byte(8'hCE, 0, nk); send_byte(8'h10, 0, nk); i2c_stop;
    i2c_start; send_byte(8'hCF, 0, nk); recv_byte(1, v); i2c_stop;
    chk(v == 8'h11, "R2 register untouched", v, 8'h11);

    // R1: strap low
    addr_strap = 1'b0; tick(Q);
    i2c_start; send_byte(8'hCE, 0, nk);
    chk(nk == 1, "R1 strap low rejects 0x67", nk, 1);
    i2c_stop;
    i2c_start; send_byte(8'h8E, 0, nk);
    chk(nk == 0, "R1 strap low accepts 0x47", nk, 0);
    send_byte(8'h60, 0, nk);
    exp_q.push_back({8'h60, 8'hA7}); send_byte(8'hA7, 0, nk);
    chk(nk == 0, "R1 data ack strap low", nk, 0);
    i2c_stop;
    addr_strap = 1'b1; tick(Q);

    // R7: repeated start
    i2c_start; send_byte(8'hCE, 0, nk); send_byte(8'h80, 0, nk);
    i2c_start; send_byte(8'hCF, 0, nk);
    chk(nk == 0, "R7 ack after repeated START", nk, 0);
    read_expect(1, 8'h80, "R7 read after repeated START");
    i2c_stop;
    tick(Q);
    chk(sda_oe == 1'b0, "R7 idle after STOP", sda_oe, 0);

    // R9: SCL glitches during a write
    i2c_start; send_byte(8'hCE, 1, nk);
    chk(nk == 0, "R9 address ack with glitches", nk, 0);
    send_byte(8'h30, 1, nk);
    exp_q.push_back({8'h30, 8'h6B}); send_byte(8'h6B, 1, nk);
    chk(nk == 0, "R9 data ack with glitches", nk, 0);
    i2c_stop;
    i2c_start; send_byte(8'hCE, 0, nk); send_byte(8'h30, 0, nk); i2c_stop;
    i2c_start; send_byte(8'hCF, 0, nk); recv_byte(1, v); i2c_stop;
    chk(v == 8'h6B, "R9 readback after glitches", v, 8'h6B);

    tick(10);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule